// File: doc/BRIEF.md
# SPI Register Command Engine

This block is an SPI master that turns simple requests into framed command sequences for an Ethernet-controller-style peripheral. A caller presents an operation, an 8-bit address, up to 16 bits of write data and a byte count. The engine then drives the serial clock, the data-out line and an active-low chip select, and it samples the data-in line. Register reads return their value on `rdata_o` with a one-cycle `done_o` pulse. Streamed buffer transfers move their payload through byte-wide valid/ready ports.

Every register access is a three-byte frame: a command byte, the address, then a data or dummy byte. A 16-bit access is split into two such frames. Streamed transfers send one command byte followed by N payload bytes inside one frame. Chip-select hold and gap intervals are given in nanoseconds and converted to whole clock cycles, rounded up.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset `cs_no` is 1, `sck_o` is 0 and `req_ready_o` is 1. Chip select stays high until a request is accepted.
- R2: The bus uses mode 0, MSB first. `sck_o` idles low and every high phase lasts exactly `CLK_DIV` clock cycles. `mosi_o` changes only while `sck_o` is low, and `miso_i` is sampled as `sck_o` rises.
- R3: 8-bit read (`req_op_i`=0) sends the frame 0x20, address, 0x00. `rdata_o` becomes {0x00, byte received during the third byte}.
- R4: 8-bit write (`req_op_i`=1) sends the frame 0x22, address, `req_wdata_i[7:0]`.
- R5: 16-bit read (op 2) and 16-bit write (op 3) each issue two frames. The first frame uses the address and the low byte. The second uses address+1 (modulo 256) and `req_wdata_i[15:8]`. Read data is {second-frame byte, first-frame byte}.
- R6: Chip select stays low for at least `HOLD_CYC` cycles after the last falling edge of `sck_o`. It then stays high for at least `GAP_CYC` cycles before the next frame. With the defaults (8 ns clock, 60 ns, 30 ns) these are 8 and 4 cycles.
- R7: Streamed read (op 4) sends 0x2C and then `req_len_i` bytes of 0x00 in one frame. Each received byte appears on `rx_data_o` with `rx_valid_o` held until `rx_ready_i`. No further byte is clocked while one is still waiting.
- R8: Streamed write (op 5) sends 0x2A and then `req_len_i` bytes taken from `tx_data_i` on valid/ready handshakes. While no byte is offered, `sck_o` stays low and `cs_no` stays low.
- R9: `req_ready_o` is high only while idle, and requests presented while it is low are ignored. `done_o` is a single-cycle pulse at the end of each operation.
- R10: Op codes 6 and 7 produce `done_o` in the cycle after acceptance, and no frame is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Engine idle, request taken |
| req_op_i | input | 3 | Operation code |
| req_addr_i | input | 8 | Register address |
| req_wdata_i | input | 16 | Register write data |
| req_len_i | input | LEN_W | Streamed byte count |
| done_o | output | 1 | Operation complete pulse |
| rdata_o | output | 16 | Register read result |
| tx_data_i | input | 8 | Streamed write byte |
| tx_valid_i | input | 1 | Streamed write byte valid |
| tx_ready_o | output | 1 | Engine takes streamed byte |
| rx_data_o | output | 8 | Streamed read byte |
| rx_valid_o | output | 1 | Streamed read byte valid |
| rx_ready_i | input | 1 | Consumer takes read byte |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| cs_no | output | 1 | Chip select, active low |
| miso_i | input | 1 | Serial data in |

## Verification
Each byte takes 16·`CLK_DIV` cycles, and a register frame is followed by `HOLD_CYC`+1 low cycles and `GAP_CYC` high cycles before `done_o`. The bench therefore waits for `done_o` within a bounded loop rather than at a fixed cycle. It reads `rdata_o` on the same falling clock edge and checks one cycle later that `done_o` has dropped. An invalid op must show `done_o` on the first falling edge after the accepting rising edge. Handshake bytes are taken on the falling edge at which valid and ready are both high, and the rising edge that follows commits them. A serial slave model logs every byte and the frame boundaries, and the edge-timing monitor measures the high phase of `sck_o`, the hold and the gap in whole cycles at falling clock edges.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam logic [2:0] OP_RD8    = 3'd0;
  localparam logic [2:0] OP_WR8    = 3'd1;
  localparam logic [2:0] OP_RD16   = 3'd2;
  localparam logic [2:0] OP_WR16   = 3'd3;
  localparam logic [2:0] OP_BUF_RD = 3'd4;
  localparam logic [2:0] OP_BUF_WR = 3'd5;

  localparam logic [7:0] CMD_REG_RD = 8'h20;
  localparam logic [7:0] CMD_REG_WR = 8'h22;
  localparam logic [7:0] CMD_BUF_RD = 8'h2C;
  localparam logic [7:0] CMD_BUF_WR = 8'h2A;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_HOLD, ST_GAP} eng_state_t;
endpackage

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
  parameter int DIV = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == CW'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!en_i)   cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_byte_shift.sv
module spi_byte_shift (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       start_i,
  input  logic [7:0] byte_i,
  input  logic       miso_i,
  output logic       busy_o,
  output logic       sck_o,
  output logic       mosi_o,
  output logic [7:0] rx_o,
  output logic       done_o
);
  logic [7:0] sh_q, rx_q;
  logic [2:0] bit_q;
  logic       sck_q, busy_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0; rx_q <= '0; bit_q <= '0;
      sck_q <= 1'b0; busy_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          sh_q   <= byte_i;
          bit_q  <= '0;
          sck_q  <= 1'b0;
          busy_q <= 1'b1;
        end
      end else if (tick_i) begin
        if (!sck_q) begin
          sck_q <= 1'b1;
          rx_q  <= {rx_q[6:0], miso_i};
        end else begin
          sck_q <= 1'b0;
          sh_q  <= {sh_q[6:0], 1'b0};
          bit_q <= bit_q + 1'b1;
          if (bit_q == 3'd7) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign sck_o  = sck_q;
  assign mosi_o = sh_q[7];
  assign rx_o   = rx_q;
  assign done_o = done_q;

  assert_mosi_steady_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_q |-> $stable(sh_q[7]));
  assert_sck_idle_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !sck_q);
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int CLK_DIV       = 5,
  parameter int CLK_PERIOD_PS = 8000,
  parameter int HOLD_NS       = 60,
  parameter int GAP_NS        = 30,
  parameter int LEN_W         = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [2:0]       req_op_i,
  input  logic [7:0]       req_addr_i,
  input  logic [15:0]      req_wdata_i,
  input  logic [LEN_W-1:0] req_len_i,
  output logic             done_o,
  output logic [15:0]      rdata_o,
  input  logic [7:0]       tx_data_i,
  input  logic             tx_valid_i,
  output logic             tx_ready_o,
  output logic [7:0]       rx_data_o,
  output logic             rx_valid_o,
  input  logic             rx_ready_i,
  output logic             sck_o,
  output logic             mosi_o,
  output logic             cs_no,
  input  logic             miso_i
);
  localparam int HOLD_RAW = (HOLD_NS * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int GAP_RAW  = (GAP_NS * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int HOLD_CYC = (HOLD_RAW < 1) ? 1 : HOLD_RAW;
  localparam int GAP_CYC  = (GAP_RAW < 1) ? 1 : GAP_RAW;

  eng_state_t       state_q;
  logic [2:0]       op_q;
  logic [7:0]       addr_q, rx_data_q;
  logic [15:0]      wdata_q, rdata_q, tmr_q;
  logic [LEN_W-1:0] len_q, idx_q;
  logic             hi_q, pend_q, done_q, cs_q, rx_valid_q;

  logic       tick, sh_start, sh_busy, sh_done;
  logic [7:0] sh_rx, tx_byte;
  logic       is_buf, is_rd, is_16, data_ph, last_byte, wr_wait;

  assign is_buf    = (op_q == OP_BUF_RD) || (op_q == OP_BUF_WR);
  assign is_rd     = (op_q == OP_RD8) || (op_q == OP_RD16);
  assign is_16     = (op_q == OP_RD16) || (op_q == OP_WR16);
  assign data_ph   = (idx_q != '0);
  assign last_byte = is_buf ? (idx_q == len_q) : (idx_q == LEN_W'(2));
  assign wr_wait   = (op_q == OP_BUF_WR) && data_ph && !tx_valid_i;

  always_comb begin
    if (!data_ph) begin
      if (is_buf) tx_byte = (op_q == OP_BUF_RD) ? CMD_BUF_RD : CMD_BUF_WR;
      else        tx_byte = is_rd ? CMD_REG_RD : CMD_REG_WR;
    end else if (is_buf) begin
      tx_byte = (op_q == OP_BUF_WR) ? tx_data_i : 8'h00;
    end else if (idx_q == LEN_W'(1)) begin
      tx_byte = addr_q;
    end else begin
      tx_byte = is_rd ? 8'h00 : (hi_q ? wdata_q[15:8] : wdata_q[7:0]);
    end
  end

  assign sh_start = (state_q == ST_RUN) && pend_q && !sh_busy && !rx_valid_q && !wr_wait;

  spi_half_tick #(.DIV(CLK_DIV)) u_tick (
    .clk_i (clk_i), .rst_ni (rst_ni), .en_i (sh_busy), .tick_o (tick)
  );

  spi_byte_shift u_shift (
    .clk_i (clk_i), .rst_ni (rst_ni), .tick_i (tick), .start_i (sh_start),
    .byte_i (tx_byte), .miso_i (miso_i), .busy_o (sh_busy), .sck_o (sck_o),
    .mosi_o (mosi_o), .rx_o (sh_rx), .done_o (sh_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE; op_q <= '0; addr_q <= '0; wdata_q <= '0;
      len_q <= '0; idx_q <= '0; hi_q <= 1'b0; pend_q <= 1'b0;
      tmr_q <= '0; done_q <= 1'b0; cs_q <= 1'b1; rdata_q <= '0;
      rx_valid_q <= 1'b0; rx_data_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (rx_valid_q && rx_ready_i) rx_valid_q <= 1'b0;
      if (sh_start) pend_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_valid_i && req_ready_o) begin
          op_q <= req_op_i; addr_q <= req_addr_i; wdata_q <= req_wdata_i;
          len_q <= req_len_i; idx_q <= '0; hi_q <= 1'b0; tmr_q <= '0;
          if (req_op_i > OP_BUF_WR) begin
            done_q <= 1'b1;
          end else begin
            cs_q    <= 1'b0;
            pend_q  <= 1'b1;
            state_q <= ST_RUN;
          end
        end
        ST_RUN: if (sh_done) begin
          if (!is_buf && is_rd && (idx_q == LEN_W'(2))) begin
            if (hi_q) rdata_q[15:8] <= sh_rx;
            else      rdata_q       <= {8'h00, sh_rx};
          end
          if ((op_q == OP_BUF_RD) && data_ph) begin
            rx_valid_q <= 1'b1;
            rx_data_q  <= sh_rx;
          end
          if (last_byte) begin
            state_q <= ST_HOLD;
            tmr_q   <= '0;
          end else begin
            idx_q  <= idx_q + 1'b1;
            pend_q <= 1'b1;
          end
        end
        ST_HOLD: if (tmr_q == 16'(HOLD_CYC - 1)) begin
          cs_q <= 1'b1; tmr_q <= '0; state_q <= ST_GAP;
        end else begin
          tmr_q <= tmr_q + 1'b1;
        end
        ST_GAP: if (tmr_q == 16'(GAP_CYC - 1)) begin
          tmr_q <= '0;
          if (is_16 && !hi_q) begin
            hi_q <= 1'b1; addr_q <= addr_q + 8'd1; idx_q <= '0;
            pend_q <= 1'b1; cs_q <= 1'b0; state_q <= ST_RUN;
          end else begin
            done_q <= 1'b1; state_q <= ST_IDLE;
          end
        end else begin
          tmr_q <= tmr_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == ST_IDLE) && !done_q && !rx_valid_q;
  assign done_o      = done_q;
  assign rdata_o     = rdata_q;
  assign cs_no       = cs_q;
  assign rx_valid_o  = rx_valid_q;
  assign rx_data_o   = rx_data_q;
  assign tx_ready_o  = (state_q == ST_RUN) && pend_q && (op_q == OP_BUF_WR) && data_ph
                       && !sh_busy && !rx_valid_q;

  // timing monitors for chip-select intervals
  logic [15:0] chk_lo_q, chk_hi_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_lo_q <= '0; chk_hi_q <= 16'hFFFF;
    end else begin
      if (sck_o) chk_lo_q <= '0;
      else if (chk_lo_q != 16'hFFFF) chk_lo_q <= chk_lo_q + 1'b1;
      if (!cs_no) chk_hi_q <= '0;
      else if (chk_hi_q != 16'hFFFF) chk_hi_q <= chk_hi_q + 1'b1;
    end
  end

  assert_idle_cs_high_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> cs_no);
  assert_sck_low_off_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sck_o);
  assert_cs_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |-> (chk_lo_q >= 16'(HOLD_CYC)));
  assert_cs_gap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> (chk_hi_q >= 16'(GAP_CYC)));
  assert_rx_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && !rx_ready_i) |=> (rx_valid_o && $stable(rx_data_o)));
  assert_tx_stall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ready_o |-> (!sck_o && !cs_no));
  assert_ready_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> cs_no);
  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: tb/sim_spi_cmd_engine.sv
module sim_spi_cmd_engine;
  localparam int DIV  = 5;
  localparam int HOLD = 8;  // 60 ns / 8 ns rounded up
  localparam int GAP  = 4;  // 30 ns / 8 ns rounded up

  logic clk = 1'b0, rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic        req_valid = 1'b0, tx_valid = 1'b0, rx_ready = 1'b0, miso = 1'b0;
  logic [2:0]  req_op = '0;
  logic [7:0]  req_addr = '0, tx_data = '0;
  logic [15:0] req_wdata = '0;
  logic [7:0]  req_len = '0;
  logic        req_ready_o, done_o, tx_ready_o, rx_valid_o, sck_o, mosi_o, cs_no;
  logic [15:0] rdata_o;
  logic [7:0]  rx_data_o;

  spi_cmd_engine #(.CLK_DIV(DIV), .CLK_PERIOD_PS(8000), .HOLD_NS(60), .GAP_NS(30), .LEN_W(8)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_ready_o(req_ready_o),
    .req_op_i(req_op), .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_len_i(req_len),
    .done_o(done_o), .rdata_o(rdata_o), .tx_data_i(tx_data), .tx_valid_i(tx_valid),
    .tx_ready_o(tx_ready_o), .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o),
    .rx_ready_i(rx_ready), .sck_o(sck_o), .mosi_o(mosi_o), .cs_no(cs_no), .miso_i(miso)
  );

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] resp(input int f, input int k);
    return {f[3:0], k[3:0]} ^ 8'h5A;
  endfunction

  // serial slave model
  logic [7:0] log_b [0:511];
  int fstart [0:63];
  int nframe = 0, nlog = 0, bitc = 0, bytec = 0;
  logic [7:0] inb = '0, outb = '0;

  always @(negedge cs_no) begin
    nframe++;
    fstart[nframe] = nlog;
    bitc = 0; bytec = 0;
    outb = resp(nframe, 0);
    miso = outb[7];
  end
  always @(posedge sck_o) if (!cs_no) begin
    inb = {inb[6:0], mosi_o};
    bitc++;
    if (bitc == 8) begin
      log_b[nlog] = inb; nlog++;
      bitc = 0; bytec++;
      outb = resp(nframe, bytec);
    end
  end
  always @(negedge sck_o) if (!cs_no) miso = outb[7 - bitc];

  // edge-timing monitor
  int hi_run = 0, hi_min = 1000, hi_max = 0, lo_since = 0, cs_hi = 0;
  int hold_min = 1000, gap_min = 1000;
  logic prev_sck = 1'b0, prev_cs = 1'b1;
  always @(negedge clk) if (rst_ni) begin
    if (sck_o) begin hi_run++; lo_since = 0; end
    else begin
      if (prev_sck) begin
        if (hi_run < hi_min) hi_min = hi_run;
        if (hi_run > hi_max) hi_max = hi_run;
      end
      hi_run = 0; lo_since++;
    end
    if (!prev_cs && cs_no && (lo_since - 1 < hold_min)) hold_min = lo_since - 1;
    if (prev_cs && !cs_no && (cs_hi < gap_min)) gap_min = cs_hi;
    cs_hi = cs_no ? cs_hi + 1 : 0;
    prev_sck = sck_o; prev_cs = cs_no;
  end

  task automatic issue(input logic [2:0] op, input logic [7:0] addr, input logic [15:0] wd,
                       input logic [7:0] len, output logic [15:0] rd, output int lat);
    @(negedge clk);
    while (!req_ready_o) @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = addr; req_wdata = wd; req_len = len;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!done_o && lat < 20000) begin @(negedge clk); lat++; end
    rd = rdata_o;
    chk(done_o, "R9 done seen", done_o, 1);
    @(negedge clk);
    chk(!done_o, "R9 done one cycle", done_o, 0);
  endtask

  task automatic chk_frame(input int f, input int n, input logic [7:0] b0, input logic [7:0] b1,
                           input logic [7:0] b2, input string tag);
    int len = ((f < nframe) ? fstart[f+1] : nlog) - fstart[f];
    chk(len == n, {tag, " frame length"}, len, n);
    chk(log_b[fstart[f]] == b0, {tag, " byte0"}, log_b[fstart[f]], b0);
    chk(log_b[fstart[f]+1] == b1, {tag, " byte1"}, log_b[fstart[f]+1], b1);
    chk(log_b[fstart[f]+2] == b2, {tag, " byte2"}, log_b[fstart[f]+2], b2);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(cs_no && !sck_o, "R1 cs/sck in reset", {cs_no, sck_o}, 2);
    rst_ni = 1'b1;
    repeat (20) @(negedge clk);
    chk(cs_no === 1'b1 && sck_o === 1'b0, "R1 idle lines", {cs_no, sck_o}, 2);
    chk(req_ready_o === 1'b1, "R1 ready", req_ready_o, 1);
    chk(nframe == 0, "R1 no frame", nframe, 0);
  endtask

  task automatic t_rd8();
    logic [15:0] rd; int lat; int f = nframe + 1;
    issue(3'd0, 8'h1A, 16'h0, 8'd0, rd, lat);
    chk_frame(f, 3, 8'h20, 8'h1A, 8'h00, "R3");
    chk(rd == {8'h00, resp(f, 2)}, "R3 rdata", rd, {8'h00, resp(f, 2)});
  endtask

  task automatic t_wr8();
    logic [15:0] rd; int lat; int f = nframe + 1;
    issue(3'd1, 8'h34, 16'h77C3, 8'd0, rd, lat);
    chk_frame(f, 3, 8'h22, 8'h34, 8'hC3, "R4");
  endtask

  task automatic t_rd16();
    logic [15:0] rd; int lat; int f = nframe + 1;
    issue(3'd2, 8'h8A, 16'h0, 8'd0, rd, lat);
    chk(nframe == f + 1, "R5 two frames", nframe - f + 1, 2);
    chk_frame(f, 3, 8'h20, 8'h8A, 8'h00, "R5 rd lo");
    chk_frame(f + 1, 3, 8'h20, 8'h8B, 8'h00, "R5 rd hi");
    chk(rd == {resp(f + 1, 2), resp(f, 2)}, "R5 rdata", rd, {resp(f + 1, 2), resp(f, 2)});
  endtask

  task automatic t_wr16();
    logic [15:0] rd; int lat; int f = nframe + 1;
    issue(3'd3, 8'hFF, 16'h1234, 8'd0, rd, lat);
    chk_frame(f, 3, 8'h22, 8'hFF, 8'h34, "R5 wr lo");
    chk_frame(f + 1, 3, 8'h22, 8'h00, 8'h12, "R5 wr hi wrap");
  endtask

  task automatic t_busy_ignore();
    logic [15:0] rd; int lat; int f = nframe + 1; int bad = 0;
    fork
      issue(3'd0, 8'h40, 16'h0, 8'd0, rd, lat);
      begin
        repeat (20) @(negedge clk);
        req_valid = 1'b1; req_op = 3'd1; req_addr = 8'h99; req_wdata = 16'h00EE;
        repeat (5) begin @(negedge clk); if (req_ready_o) bad++; end
        req_valid = 1'b0;
      end
    join
    chk(bad == 0, "R9 ready low while busy", bad, 0);
    chk(nframe == f, "R9 busy request ignored", nframe - f + 1, 1);
    chk_frame(f, 3, 8'h20, 8'h40, 8'h00, "R9");
  endtask

  task automatic t_buf_rd();
    logic [15:0] rd; int lat; int f = nframe + 1; int viol = 0;
    logic [7:0] got [1:4];
    fork
      issue(3'd4, 8'h00, 16'h0, 8'd4, rd, lat);
      for (int k = 1; k <= 4; k++) begin
        while (!rx_valid_o) @(negedge clk);
        if (k == 2) repeat (30) begin
          @(negedge clk);
          if (sck_o || cs_no || !rx_valid_o) viol++;
        end
        rx_ready = 1'b1; got[k] = rx_data_o;
        @(negedge clk);
        rx_ready = 1'b0;
      end
    join
    chk(viol == 0, "R7 clock held while byte waits", viol, 0);
    chk(fstart[f] + 5 == ((f < nframe) ? fstart[f+1] : nlog), "R7 frame length",
        nlog - fstart[f], 5);
    chk(log_b[fstart[f]] == 8'h2C, "R7 command", log_b[fstart[f]], 8'h2C);
    for (int k = 1; k <= 4; k++) begin
      chk(log_b[fstart[f]+k] == 8'h00, "R7 dummy out", log_b[fstart[f]+k], 0);
      chk(got[k] == resp(f, k), "R7 rx byte", got[k], resp(f, k));
    end
  endtask

  task automatic t_buf_wr();
    logic [15:0] rd; int lat; int f = nframe + 1; int viol = 0;
    logic [7:0] pay [0:2];
    pay[0] = 8'hA5; pay[1] = 8'h3C; pay[2] = 8'hF0;
    fork
      issue(3'd5, 8'h00, 16'h0, 8'd3, rd, lat);
      for (int k = 0; k < 3; k++) begin
        if (k == 1) begin
          while (!tx_ready_o) @(negedge clk);
          repeat (40) begin
            @(negedge clk);
            if (sck_o || cs_no) viol++;
          end
        end
        tx_valid = 1'b1; tx_data = pay[k];
        while (!tx_ready_o) @(negedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
      end
    join
    chk(viol == 0, "R8 stall keeps sck low cs low", viol, 0);
    chk(log_b[fstart[f]] == 8'h2A, "R8 command", log_b[fstart[f]], 8'h2A);
    for (int k = 0; k < 3; k++)
      chk(log_b[fstart[f]+1+k] == pay[k], "R8 payload", log_b[fstart[f]+1+k], pay[k]);
    chk(nlog - fstart[f] == 4, "R8 frame length", nlog - fstart[f], 4);
  endtask

  task automatic t_bad_op();
    logic [15:0] rd; int lat; int f0 = nframe;
    issue(3'd6, 8'h12, 16'h0, 8'd0, rd, lat);
    chk(lat == 0, "R10 op6 done next cycle", lat, 0);
    issue(3'd7, 8'h12, 16'h0, 8'd0, rd, lat);
    chk(lat == 0, "R10 op7 done next cycle", lat, 0);
    chk(nframe == f0, "R10 no frame", nframe, f0);
    chk(cs_no === 1'b1, "R10 cs high", cs_no, 1);
  endtask

  task automatic t_timing();
    chk(hi_min == DIV && hi_max == DIV, "R2 sck high phase", hi_max, DIV);
    chk(hold_min >= HOLD, "R6 cs hold", hold_min, HOLD);
    chk(gap_min >= GAP, "R6 cs gap", gap_min, GAP);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=0", 150000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_rd8();
    t_wr8();
    t_rd16();
    t_wr16();
    t_busy_ignore();
    t_buf_rd();
    t_buf_wr();
    t_bad_op();
    t_timing();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule